// File: doc/BRIEF.md
# Converter Conversion Sequencer with Register Front End

This block sits between a host register bus and a 10-bit successive-approximation converter core. Software programs a control word (power, input channel, reference choice, sync gating and a start bit), then polls a read-only result word until its valid flag rises. The block recognises start requests and can hold a conversion until an external sync pin fires. It times the conversion, latches the result together with the valid flag, and emits a one-cycle completion pulse that also appears on a 16-bit interrupt source vector.

The analog sampling path is replaced by a behavioural model. One 10-bit level per input channel arrives on a flat input bus. The result of a conversion is the level of the channel that was latched when the start was accepted, read out when the conversion completes.

Top module: `adc_ctl_top`

## Requirements
- R1: After reset the control word reads 0x0000, the result word reads 0x0000, `done_o` is low and `pwr_o` is low.
- R2: Control word bit fields: bit 15 powers the converter (`pwr_o`), bit 7 is start, bit 5 picks the external reference (`ref_ext_o`), bits 4:2 select the channel and bit 0 enables sync. Reading it back returns the written value with every other bit forced to 0.
- R3: The control word sits at address 0 and the result word at address 1. Any other address reads 0x0000. The result word is read-only, so a write to it leaves its contents unchanged.
- R4: The result word carries the valid flag in bit 15 and the result in bits 9:0. Bits 14:10 read 0.
- R5: A start is accepted when all of the following hold: a control write sets bit 7, the stored bit 7 is 0, bit 15 is set both in the stored word and in the written word, and no conversion is pending. Acceptance clears valid on that clock edge. Without sync, valid is set exactly LATENCY clock edges after the accepting write edge.
- R6: Completion raises `done_o` for exactly one cycle, in the same cycle valid rises. `irq_src_o` carries `done_o` in bit 11 and 0 in every other bit.
- R7: Channel codes 0 to 3 select the X+, X-, Y+ and Y- panel terminals. Codes 4 to 7 select auxiliary inputs 0 to 3. The result equals `levels_i[code*10 +: 10]` for the code latched at the accepted start. Rewriting the channel during a conversion does not change that result.
- R8: When bit 0 is set in the accepted start write, the conversion begins only at the first clock edge where `sync_i` is seen high after being seen low. Valid rises LATENCY edges later. A level that was already high when the start was accepted does not count.
- R9: A start write issued while the stored bit 15 is 0 is ignored, even when that same write sets both bit 15 and bit 7. Valid does not change and no done pulse occurs.
- R10: A start issued while a conversion is pending (waiting for sync or counting) is ignored. The running conversion completes at its original time with its original channel.
- R11: A control write with bit 15 clear during a pending conversion aborts it. Valid stays 0 and no done pulse follows.
- R12: Writing bit 7 again over a stored bit 7 of 1 starts nothing. Valid stays as it was and no done pulse occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| sync_i | input | 1 | External conversion sync pin, synchronous to `clk` |
| levels_i | input | 80 | Behavioural channel levels, 10 bits per channel code |
| pwr_o | output | 1 | Converter power enable |
| ref_ext_o | output | 1 | External reference select |
| chan_o | output | 3 | Channel latched for the current or last conversion |
| done_o | output | 1 | One-cycle completion pulse |
| irq_src_o | output | 16 | Interrupt source vector, completion on bit 11 |

## Verification
Directed conversions are run on all eight channel codes with distinct levels, which separates errors in the channel decode and the slice selection. The start path is exercised in several ways: starts issued while powered down, while busy, and by rewriting a start bit that is already set. Each must leave the valid flag and the done count untouched, which distinguishes a correct start edge detector from a level-sensitive one. Sync-gated runs hold the sync pin high before the start and release it late, which exposes a level-triggered gate and an off-by-one in the latency count. Aborts during the count and during the sync wait check that valid never rises. A seeded random mix of channels, levels, reference choice and sync gating compares every result against a bench-side model.

// File: rtl/adc_ctl_pkg.sv
package adc_ctl_pkg;

    localparam int WORD_W       = 16;
    localparam int RES_W        = 10;
    localparam int SEL_W        = 3;
    localparam int NUM_CH       = 1 << SEL_W;
    localparam int DONE_IRQ_BIT = 11;

    typedef struct packed {
        logic             en;
        logic             start;
        logic             ext_ref;
        logic [SEL_W-1:0] sel;
        logic             sync_en;
    } ctrl_t;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_WAIT_SYNC = 2'd1,
        ST_CONV      = 2'd2
    } seq_state_e;

    function automatic ctrl_t unpack_ctrl(input logic [WORD_W-1:0] w);
        ctrl_t c;
        c.en      = w[15];
        c.start   = w[7];
        c.ext_ref = w[5];
        c.sel     = w[4:2];
        c.sync_en = w[0];
        return c;
    endfunction

    function automatic logic [WORD_W-1:0] pack_ctrl(input ctrl_t c);
        return {c.en, 7'b0, c.start, 1'b0, c.ext_ref, c.sel, 1'b0, c.sync_en};
    endfunction

    function automatic logic [WORD_W-1:0] pack_data(input logic v,
                                                    input logic [RES_W-1:0] r);
        return {v, {(WORD_W-RES_W-1){1'b0}}, r};
    endfunction

endpackage

// File: rtl/adc_ctl_regfile.sv
module adc_ctl_regfile
    import adc_ctl_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int CTRL_ADDR = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    input  logic              seq_idle,
    output ctrl_t             ctrl_q,
    output logic              start_req,
    output logic              start_sync,
    output logic [SEL_W-1:0]  start_sel,
    output logic              abort_req
);

    logic  wr_ctrl;
    ctrl_t wr_val;

    assign wr_ctrl = bus_we && (bus_addr == ADDR_W'(CTRL_ADDR));
    assign wr_val  = unpack_ctrl(bus_wdata);

    // Start is an edge of the stored start bit, qualified by prior power-up.
    assign start_req  = wr_ctrl && wr_val.start && !ctrl_q.start &&
                        ctrl_q.en && wr_val.en && seq_idle;
    assign start_sync = wr_val.sync_en;
    assign start_sel  = wr_val.sel;
    assign abort_req  = wr_ctrl && !wr_val.en && !seq_idle;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (wr_ctrl) begin
            ctrl_q <= wr_val;
        end
    end

endmodule

// File: rtl/adc_ctl_seq.sv
module adc_ctl_seq
    import adc_ctl_pkg::*;
#(
    parameter int LATENCY = 12
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start_req,
    input  logic       start_sync,
    input  logic       abort_req,
    input  logic       sync_i,
    output seq_state_e state_q,
    output logic       finish,
    output logic       done_q
);

    localparam int CNT_W = (LATENCY > 1) ? $clog2(LATENCY) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(LATENCY - 1);

    logic             sync_q;
    logic             sync_rise;
    logic [CNT_W-1:0] cnt_q;

    assign sync_rise = sync_i && !sync_q;
    assign finish    = (state_q == ST_CONV) && !abort_req && (cnt_q == CNT_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            sync_q  <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            sync_q <= sync_i;
            done_q <= finish;
            unique case (state_q)
                ST_IDLE: begin
                    if (start_req) begin
                        state_q <= start_sync ? ST_WAIT_SYNC : ST_CONV;
                        cnt_q   <= '0;
                    end
                end
                ST_WAIT_SYNC: begin
                    if (abort_req) begin
                        state_q <= ST_IDLE;
                    end else if (sync_rise) begin
                        state_q <= ST_CONV;
                        cnt_q   <= '0;
                    end
                end
                ST_CONV: begin
                    if (abort_req || finish) begin
                        state_q <= ST_IDLE;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/adc_ctl_conv_model.sv
module adc_ctl_conv_model
    import adc_ctl_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic [NUM_CH*RES_W-1:0] levels_i,
    input  logic                    start_req,
    input  logic [SEL_W-1:0]        start_sel,
    input  logic                    finish,
    output logic                    valid_q,
    output logic [RES_W-1:0]        result_q,
    output logic [SEL_W-1:0]        conv_sel_q
);

    logic [RES_W-1:0] lvl [NUM_CH];

    for (genvar g = 0; g < NUM_CH; g++) begin : g_split
        assign lvl[g] = levels_i[g*RES_W +: RES_W];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q    <= 1'b0;
            result_q   <= '0;
            conv_sel_q <= '0;
        end else if (start_req) begin
            valid_q    <= 1'b0;
            conv_sel_q <= start_sel;
        end else if (finish) begin
            valid_q  <= 1'b1;
            result_q <= lvl[conv_sel_q];
        end
    end

endmodule

// File: rtl/adc_ctl_top.sv
module adc_ctl_top
    import adc_ctl_pkg::*;
#(
    parameter int LATENCY   = 12,
    parameter int ADDR_W    = 4,
    parameter int CTRL_ADDR = 0,
    parameter int DATA_ADDR = 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    bus_we,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic [WORD_W-1:0]       bus_wdata,
    output logic [WORD_W-1:0]       bus_rdata,
    input  logic                    sync_i,
    input  logic [NUM_CH*RES_W-1:0] levels_i,
    output logic                    pwr_o,
    output logic                    ref_ext_o,
    output logic [SEL_W-1:0]        chan_o,
    output logic                    done_o,
    output logic [WORD_W-1:0]       irq_src_o
);

    ctrl_t            ctrl_q;
    logic             start_req, start_sync, abort_req;
    logic [SEL_W-1:0] start_sel;
    seq_state_e       state_q;
    logic             finish, done_q;
    logic             valid_q;
    logic [RES_W-1:0] result_q;

    adc_ctl_regfile #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .seq_idle   (state_q == ST_IDLE),
        .ctrl_q     (ctrl_q),
        .start_req  (start_req),
        .start_sync (start_sync),
        .start_sel  (start_sel),
        .abort_req  (abort_req)
    );

    adc_ctl_seq #(.LATENCY(LATENCY)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start_req  (start_req),
        .start_sync (start_sync),
        .abort_req  (abort_req),
        .sync_i     (sync_i),
        .state_q    (state_q),
        .finish     (finish),
        .done_q     (done_q)
    );

    adc_ctl_conv_model u_model (
        .clk        (clk),
        .rst        (rst),
        .levels_i   (levels_i),
        .start_req  (start_req),
        .start_sel  (start_sel),
        .finish     (finish),
        .valid_q    (valid_q),
        .result_q   (result_q),
        .conv_sel_q (chan_o)
    );

    assign pwr_o     = ctrl_q.en;
    assign ref_ext_o = ctrl_q.ext_ref;
    assign done_o    = done_q;

    for (genvar b = 0; b < WORD_W; b++) begin : g_irq
        if (b == DONE_IRQ_BIT) begin : g_src
            assign irq_src_o[b] = done_q;
        end else begin : g_zero
            assign irq_src_o[b] = 1'b0;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(CTRL_ADDR)) begin
            bus_rdata = pack_ctrl(ctrl_q);
        end else if (bus_addr == ADDR_W'(DATA_ADDR)) begin
            bus_rdata = pack_data(valid_q, result_q);
        end
    end

endmodule

// File: rtl/adc_ctl_checker.sv
module adc_ctl_checker
    import adc_ctl_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int CTRL_ADDR = 0,
    parameter int DATA_ADDR = 1
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [WORD_W-1:0] bus_wdata,
    input logic              sync_i,
    input logic              done_o,
    input logic [WORD_W-1:0] irq_src_o,
    input seq_state_e        state_q,
    input logic              valid_q,
    input logic [RES_W-1:0]  result_q
);

    logic wr_ctrl, wr_data;
    assign wr_ctrl = bus_we && (bus_addr == ADDR_W'(CTRL_ADDR));
    assign wr_data = bus_we && (bus_addr == ADDR_W'(DATA_ADDR));

    p_done_single_r6: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    p_done_valid_r6: assert property (@(posedge clk) disable iff (rst)
        done_o |-> valid_q);

    p_irq_onehot_r6: assert property (@(posedge clk) disable iff (rst)
        $countones(irq_src_o) <= 1);

    p_abort_r11: assert property (@(posedge clk) disable iff (rst)
        (wr_ctrl && !bus_wdata[15]) |=> (state_q == ST_IDLE && !done_o));

    p_data_ro_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_data && state_q == ST_IDLE) |=> ($stable(result_q) && $stable(valid_q)));

    p_sync_gate_r8: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WAIT_SYNC && !sync_i) |=> state_q != ST_CONV);

endmodule

bind adc_ctl_top adc_ctl_checker #(
    .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR), .DATA_ADDR(DATA_ADDR)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .sync_i    (sync_i),
    .done_o    (done_o),
    .irq_src_o (irq_src_o),
    .state_q   (state_q),
    .valid_q   (valid_q),
    .result_q  (result_q)
);

// File: tb/adc_ctl_top_bench.sv
module adc_ctl_top_bench;

    localparam int LAT    = 12;
    localparam int AW     = 4;
    localparam int CTRL_A = 0;
    localparam int DATA_A = 1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_we = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        sync_i = 1'b0;
    logic [79:0] levels;
    logic        pwr_o, ref_ext_o, done_o;
    logic [2:0]  chan_o;
    logic [15:0] irq_src_o;
    logic [9:0]  lv [8];

    int tests = 0;
    int fails = 0;
    int done_seen = 0;

    always #2.5 clk = ~clk;

    always_comb begin
        for (int i = 0; i < 8; i++) levels[i*10 +: 10] = lv[i];
    end

    always @(posedge clk) if (!rst && done_o) done_seen <= done_seen + 1;

    adc_ctl_top #(.LATENCY(LAT), .ADDR_W(AW), .CTRL_ADDR(CTRL_A), .DATA_ADDR(DATA_A)) u_adc_ctl_top (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sync_i(sync_i),
        .levels_i(levels), .pwr_o(pwr_o), .ref_ext_o(ref_ext_o),
        .chan_o(chan_o), .done_o(done_o), .irq_src_o(irq_src_o)
    );

    function automatic logic [15:0] mkw(logic en, logic st, logic rf,
                                        logic [2:0] sel, logic sy);
        return {en, 7'b0, st, 1'b0, rf, sel, 1'b0, sy};
    endfunction

    function automatic logic [15:0] exp_data(logic v, logic [9:0] r);
        return {v, 5'b0, r};
    endfunction

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
        end
    endtask

    task automatic wr(int a, logic [15:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = AW'(a); bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(int a, output logic [15:0] d);
        bus_addr = AW'(a);
        #0.5;
        d = bus_rdata;
    endtask

    task automatic cycles(int n);
        repeat (n) @(negedge clk);
    endtask

    // Full start/complete sequence with exact-cycle checks.
    task automatic run_conv(logic [2:0] sel, logic sy, logic rf, string tag);
        logic [15:0] d;
        int d0;
        wr(CTRL_A, mkw(1'b1, 1'b0, rf, sel, sy));
        wr(CTRL_A, mkw(1'b1, 1'b1, rf, sel, sy));
        d0 = done_seen;
        rd(DATA_A, d);
        check({tag, " R5 valid cleared at start"}, {15'b0, d[15]}, 16'd0);
        if (sy) begin
            cycles(5);
            rd(DATA_A, d);
            check({tag, " R8 waits for sync"}, {15'b0, d[15]}, 16'd0);
            sync_i = 1'b1;
            @(negedge clk);
            sync_i = 1'b0;
        end
        cycles(LAT - 1);
        rd(DATA_A, d);
        check({tag, " R5 not valid before latency"}, {15'b0, d[15]}, 16'd0);
        @(negedge clk);
        rd(DATA_A, d);
        check({tag, " R7 R4 result word"}, d, exp_data(1'b1, lv[sel]));
        check({tag, " R6 done high"}, {15'b0, done_o}, 16'd1);
        check({tag, " R6 irq vector"}, irq_src_o, 16'h0800);
        @(negedge clk);
        check({tag, " R6 done one cycle"}, {15'b0, done_o}, 16'd0);
        check({tag, " R6 single pulse"}, 16'(done_seen - d0), 16'd1);
        check({tag, " R2 ref pin"}, {15'b0, ref_ext_o}, {15'b0, rf});
    endtask

    initial begin : main
        logic [15:0] d;
        int d0;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 8; i++) lv[i] = 10'(37 * i + 100 + i);
        cycles(3);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(CTRL_A, d); check("R1 ctrl after reset", d, 16'h0000);
        rd(DATA_A, d); check("R1 data after reset", d, 16'h0000);
        check("R1 done low", {15'b0, done_o}, 16'd0);
        check("R1 power off", {15'b0, pwr_o}, 16'd0);

        // R2 field mask, R9 start while powered down
        d0 = done_seen;
        wr(CTRL_A, 16'hFFFF);
        rd(CTRL_A, d); check("R2 readback mask", d, 16'h80BD);
        check("R2 power pin", {15'b0, pwr_o}, 16'd1);
        check("R2 ext ref pin", {15'b0, ref_ext_o}, 16'd1);
        cycles(LAT + 3);
        rd(DATA_A, d); check("R9 no conversion from off", d, 16'h0000);
        check("R9 no done", 16'(done_seen - d0), 16'd0);

        // R3 map and read-only data
        rd(5, d); check("R3 unmapped reads zero", d, 16'h0000);
        wr(DATA_A, 16'hFFFF);
        rd(DATA_A, d); check("R3 data read-only", d, 16'h0000);
        wr(CTRL_A, 16'h0000);
        rd(CTRL_A, d); check("R2 disable clears ctrl", d, 16'h0000);
        check("R2 power off", {15'b0, pwr_o}, 16'd0);

        // R5 R6 R7 every channel code
        for (int c = 0; c < 8; c++) run_conv(3'(c), 1'b0, c[0], "chan");
        rd(DATA_A, d);
        wr(DATA_A, 16'h1234);
        begin
            logic [15:0] d2;
            rd(DATA_A, d2); check("R3 write to data ignored", d2, d);
        end

        // R10 start while busy, channel change mid-run
        wr(CTRL_A, mkw(1, 0, 0, 3'd1, 0));
        wr(CTRL_A, mkw(1, 1, 0, 3'd1, 0));
        d0 = done_seen;
        wr(CTRL_A, mkw(1, 0, 0, 3'd6, 0));
        wr(CTRL_A, mkw(1, 1, 0, 3'd6, 0));
        cycles(LAT - 5);
        rd(DATA_A, d); check("R10 still pending", {15'b0, d[15]}, 16'd0);
        @(negedge clk);
        rd(DATA_A, d); check("R10 original timing and channel", d, exp_data(1'b1, lv[1]));
        check("R10 chan latched", {13'b0, chan_o}, 16'd1);
        cycles(LAT + 2);
        check("R10 only one done", 16'(done_seen - d0), 16'd1);

        // R12 re-writing a set start bit
        d0 = done_seen;
        wr(CTRL_A, mkw(1, 1, 0, 3'd6, 0));
        rd(DATA_A, d); check("R12 valid kept", d, exp_data(1'b1, lv[1]));
        cycles(LAT + 2);
        check("R12 no done", 16'(done_seen - d0), 16'd0);

        // R11 abort while counting
        wr(CTRL_A, mkw(1, 0, 0, 3'd2, 0));
        wr(CTRL_A, mkw(1, 1, 0, 3'd2, 0));
        d0 = done_seen;
        cycles(4);
        wr(CTRL_A, 16'h0000);
        cycles(LAT + 3);
        rd(DATA_A, d); check("R11 abort count valid low", {15'b0, d[15]}, 16'd0);
        check("R11 abort count no done", 16'(done_seen - d0), 16'd0);

        // R11 abort while waiting for sync
        wr(CTRL_A, mkw(1, 0, 0, 3'd3, 1));
        wr(CTRL_A, mkw(1, 1, 0, 3'd3, 1));
        d0 = done_seen;
        cycles(3);
        wr(CTRL_A, 16'h0000);
        sync_i = 1'b1; cycles(2); sync_i = 1'b0;
        cycles(LAT + 3);
        rd(DATA_A, d); check("R11 abort sync valid low", {15'b0, d[15]}, 16'd0);
        check("R11 abort sync no done", 16'(done_seen - d0), 16'd0);

        // R8 sync level already high does not count
        sync_i = 1'b1;
        wr(CTRL_A, mkw(1, 0, 0, 3'd5, 1));
        wr(CTRL_A, mkw(1, 1, 0, 3'd5, 1));
        cycles(LAT + 4);
        rd(DATA_A, d); check("R8 high level ignored", {15'b0, d[15]}, 16'd0);
        sync_i = 1'b0;
        cycles(2);
        sync_i = 1'b1;
        @(negedge clk);
        sync_i = 1'b0;
        cycles(LAT - 1);
        rd(DATA_A, d); check("R8 not before latency", {15'b0, d[15]}, 16'd0);
        @(negedge clk);
        rd(DATA_A, d); check("R8 after rise", d, exp_data(1'b1, lv[5]));

        // R8 directed sync run and random mix
        run_conv(3'd4, 1'b1, 1'b0, "sync");
        for (int n = 0; n < 30; n++) begin
            for (int i = 0; i < 8; i++) lv[i] = 10'($urandom);
            run_conv(3'($urandom), 1'($urandom), 1'($urandom), "rand");
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule